// File: doc/BRIEF.md
# Inter-Core Event Flag Hub

This block sits between one main processor core and two secondary processor cores. Each core raises a transmit-event pulse when it executes its send-event instruction. The hub brings each pulse into the system clock domain and turns its rising edge into a one-cycle set strobe. That strobe sets a sticky flag. Each flag drives a level interrupt toward the other side, with no enable stage in between. The main core's flag drives one shared interrupt line that both secondary cores receive together. Each secondary core's flag drives its own interrupt line back to the main core.

Software reaches the three flags through a small word-addressed register port. Address 0 holds the main core's flag. Address 1 holds the flag of secondary core A and address 2 the flag of secondary core B. A write with data bit 0 at 1 sets the addressed flag, exactly as a hardware event does. A write with data bit 0 at 0 clears it. A flag stays set until software clears it, so a handler that returns without clearing its flag is interrupted again at once.

Top module: `core_event_hub`

## Requirements
- R1: While rst_n is low at a clock edge, every flag goes to 0 after that edge. All interrupt outputs and all read data are 0 after reset.
- R2: A rising edge on an event input sets the matching flag. The input passes two synchroniser stages, then the flag register. So the flag and its interrupt are first seen high after the third rising clock edge after the input goes high, and are still low after the second.
- R3: An event input that stays high sets its flag only once. After software clears the flag, the input must go low and then high again before the flag is set again.
- R4: A set flag stays 1 for any number of cycles until a register write with data bit 0 equal to 0 reaches its address. That write clears the flag on the next clock edge.
- R5: A register write with data bit 0 equal to 1 sets the flag at the written address on the next clock edge. Address 0 is the main flag, address 1 is secondary A and address 2 is secondary B.
- R6: irq_sec_o, the interrupt line shared by both secondary cores, equals the main flag (address 0). Secondary events never raise it.
- R7: irq_main_o bit 0 equals the secondary A flag (address 1) and bit 1 equals the secondary B flag (address 2). Neither needs an enable.
- R8: If a hardware set strobe and a clearing write hit the same flag in the same cycle, the flag is 1 afterwards.
- R9: reg_rdata returns the addressed flag in bit 0 and zeros in every other bit. Address 3 reads as all zeros, and writes to address 3 change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_main_i | input | 1 | Transmit-event pulse from the main core; may be asynchronous |
| evt_sec_i | input | 2 | Transmit-event pulses from secondary cores A (bit 0) and B (bit 1) |
| reg_addr | input | 2 | Flag register word address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data; only bit 0 is used |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_sec_o | output | 1 | Shared interrupt to both secondary cores |
| irq_main_o | output | 2 | Dedicated interrupts to the main core, one per secondary core |

## Verification
The checker watches several rules on every cycle. A set strobe lasts one cycle and always leaves its flag at 1. A software set always takes effect. A flag can fall only after a clearing write to its own address, and the set strobe wins against that write. Each interrupt output matches the read data of its flag's address, and the unused read bits are always zero. Other behaviour can only be shown by the bench's scenarios. These are the exact three-edge latency from an event input, the refusal of a held-high input to set its flag again after a clear, and the way a sequence of register writes moves the flags as a group.

// File: rtl/evt_hub_pkg.sv
// Package: shared constants and types for the inter-core event hub.
// Assumes source index 0 is the main core and indices 1.. are secondaries.
package evt_hub_pkg;
    localparam int SRC_MAIN = 0;

    // Per-flag command decoded from the register port.
    typedef struct packed {
        logic set;
        logic clr;
    } flag_cmd_t;
endpackage

// File: rtl/evt_edge_sync.sv
// Module: evt_edge_sync
// Brings one asynchronous event level into the clk domain through STAGES
// flops, then emits a one-cycle strobe on its rising edge.
// Assumes the source holds its pulse longer than one clk period.
module evt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_async,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchroniser chain and delayed copy for the edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], evt_async};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // Strobe on a 0 -> 1 change of the synchronised level.
    always_comb rise_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/evt_flag.sv
// Module: evt_flag
// One sticky event flag. Hardware strobe and software set both set it;
// a software clear resets it unless a set arrives in the same cycle.
module evt_flag
    import evt_hub_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hw_set,
    input  flag_cmd_t sw_cmd,
    output logic      flag_q
);
    // Flag update: any set outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (hw_set || sw_cmd.set)  flag_q <= 1'b1;
        else if (sw_cmd.clr)            flag_q <= 1'b0;
    end
endmodule

// File: rtl/evt_regif.sv
// Module: evt_regif
// Decodes register writes into per-flag set/clear commands and muxes the
// addressed flag onto the read bus. Addresses past N_SRC read zero and
// their writes are dropped.
module evt_regif
    import evt_hub_pkg::*;
#(
    parameter int N_SRC = 3,
    parameter int AW    = 2,
    parameter int DW    = 32
) (
    input  logic                reg_wr,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    input  logic [N_SRC-1:0]    flags,
    output flag_cmd_t           cmd [N_SRC],
    output logic [DW-1:0]       reg_rdata
);
    for (genvar k = 0; k < N_SRC; k++) begin : g_dec
        logic hit;
        // Address match for flag k.
        always_comb hit = reg_wr && (reg_addr == AW'(k));
        // Split write into set or clear by data bit 0.
        always_comb begin
            cmd[k].set = hit &  reg_wdata[0];
            cmd[k].clr = hit & ~reg_wdata[0];
        end
    end

    // Read mux: flag in bit 0, zeros elsewhere.
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (reg_addr == AW'(k)) reg_rdata[0] = flags[k];
        end
    end
endmodule

// File: rtl/core_event_hub.sv
// Module: core_event_hub (top)
// Captures transmit-event pulses from one main and N_SEC secondary cores
// into sticky flags and routes them as level interrupts: the main flag to a
// line shared by all secondaries, each secondary flag to its own main line.
// Assumes one synchronous clock for the register port and the flags.
module core_event_hub
    import evt_hub_pkg::*;
#(
    parameter int N_SEC       = 2,
    parameter int AW          = 2,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_main_i,
    input  logic [N_SEC-1:0] evt_sec_i,
    input  logic [AW-1:0]    reg_addr,
    input  logic             reg_wr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq_sec_o,
    output logic [N_SEC-1:0] irq_main_o
);
    localparam int N_SRC = N_SEC + 1;

    logic [N_SRC-1:0] evt_raw;
    logic [N_SRC-1:0] hw_edge;
    logic [N_SRC-1:0] flag_q;
    flag_cmd_t        sw_cmd [N_SRC];

    // Gather sources: index 0 main, then secondaries in order.
    always_comb evt_raw = {evt_sec_i, evt_main_i};

    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_async  (evt_raw[k]),
            .rise_pulse (hw_edge[k])
        );
        evt_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (hw_edge[k]),
            .sw_cmd (sw_cmd[k]),
            .flag_q (flag_q[k])
        );
    end

    evt_regif #(.N_SRC(N_SRC), .AW(AW), .DW(DW)) u_regif (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flags     (flag_q),
        .cmd       (sw_cmd),
        .reg_rdata (reg_rdata)
    );

    // Interrupt routing: broadcast main flag, dedicated secondary lines.
    always_comb begin
        irq_sec_o  = flag_q[SRC_MAIN];
        irq_main_o = flag_q[N_SRC-1:1];
    end
endmodule

// File: rtl/evt_hub_checker.sv
// Module: evt_hub_checker
// Cycle-by-cycle rules on the hub, bound into core_event_hub.
module evt_hub_checker #(
    parameter int N_SRC = 3,
    parameter int AW    = 2,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] flags,
    input  logic [N_SRC-1:0] set_hw,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic [DW-1:0]    reg_rdata,
    input  logic             irq_sec_o,
    input  logic [N_SRC-2:0] irq_main_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (flags == '0));

    assert_rdata_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:1] == '0);

    assert_unmapped_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) >= N_SRC) |-> (reg_rdata == '0));

    assert_shared_irq_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(0)) |-> (irq_sec_o == reg_rdata[0]));

    for (genvar k = 0; k < N_SRC; k++) begin : g_chk
        logic clr_hit;
        always_comb clr_hit = reg_wr && (reg_addr == AW'(k)) && !reg_wdata[0];

        assert_hw_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            set_hw[k] |=> flags[k]);

        assert_one_shot_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_hw[k] |=> !set_hw[k]);

        assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[k] && !clr_hit) |=> flags[k]);

        assert_sw_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == AW'(k) && reg_wdata[0]) |=> flags[k]);

        assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (set_hw[k] && clr_hit) |=> flags[k]);

        if (k > 0) begin : g_main_line
            assert_dedicated_irq_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_addr == AW'(k)) |-> (irq_main_o[k-1] == reg_rdata[0]));
        end
    end
endmodule

bind core_event_hub evt_hub_checker #(.N_SRC(N_SRC), .AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags      (flag_q),
    .set_hw     (hw_edge),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_sec_o  (irq_sec_o),
    .irq_main_o (irq_main_o)
);

// File: tb/sim_core_event_hub.sv
module sim_core_event_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_main_i = 1'b0;
    logic [1:0]  evt_sec_i = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_sec_o;
    logic [1:0]  irq_main_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    core_event_hub u0 (
        .clk(clk), .rst_n(rst_n), .evt_main_i(evt_main_i), .evt_sec_i(evt_sec_i),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_sec_o(irq_sec_o), .irq_main_o(irq_main_o)
    );

    // Register-sequence vectors: write bit to addr, expected {B,A,main} after.
    typedef struct packed {
        logic [1:0] addr;
        logic       wbit;
        logic [2:0] exp;
    } vec_t;
    localparam vec_t VEC [10] = '{
        '{2'd1, 1'b1, 3'b010}, '{2'd0, 1'b1, 3'b011}, '{2'd2, 1'b1, 3'b111},
        '{2'd1, 1'b0, 3'b101}, '{2'd3, 1'b1, 3'b101}, '{2'd0, 1'b0, 3'b100},
        '{2'd3, 1'b0, 3'b100}, '{2'd1, 1'b1, 3'b110}, '{2'd2, 1'b0, 3'b010},
        '{2'd1, 1'b0, 3'b000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic b);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = {31'd0, b};
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    function automatic logic [2:0] irq_flags();
        return {irq_main_o, irq_sec_o};
    endfunction

    // Reads all three flags through the register port and compares.
    task automatic check_all(input string tag, input logic [2:0] exp);
        check({tag, " irq"}, {29'd0, irq_flags()}, {29'd0, exp});
        for (int a = 0; a < 3; a++) begin
            reg_addr = 2'(a);
            #1;
            check({tag, " read"}, reg_rdata, {31'd0, exp[a]});
        end
    endtask

    task automatic wait_negs(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        wait_negs(3);
        // R1: reset state
        check_all("R1 reset", 3'b000);
        reg_addr = 2'd3; #1;
        check("R1 R9 addr3 read", reg_rdata, 32'd0);
        rst_n = 1'b1;
        wait_negs(1);

        // R5 R6 R7 R9: table walk of register writes.
        for (int v = 0; v < 10; v++) begin
            wr(VEC[v].addr, VEC[v].wbit);
            check_all($sformatf("R5 R6 R7 R9 vec%0d", v), VEC[v].exp);
        end

        // R2: exact latency from main event input; R6 shared line.
        @(negedge clk); evt_main_i = 1'b1;
        wait_negs(2);
        check("R2 before 3rd edge", {31'd0, irq_sec_o}, 32'd0);
        wait_negs(1);
        check("R2 at 3rd edge", {31'd0, irq_sec_o}, 32'd1);
        check("R6 no dedicated line", {30'd0, irq_main_o}, 32'd0);

        // R3: clear while input held high; no re-set.
        wr(2'd0, 1'b0);
        wait_negs(5);
        check_all("R3 held high no reset", 3'b000);
        evt_main_i = 1'b0;
        wait_negs(3);
        evt_main_i = 1'b1;
        wait_negs(4);
        check_all("R3 new edge sets", 3'b001);
        evt_main_i = 1'b0;
        wr(2'd0, 1'b0);

        // R7 R4: secondary A event, sticky over many cycles.
        evt_sec_i = 2'b01;
        wait_negs(3);
        evt_sec_i = 2'b00;
        wait_negs(1);
        check_all("R7 secondary A", 3'b010);
        wait_negs(25);
        check_all("R4 sticky", 3'b010);
        wr(2'd1, 1'b0);
        check_all("R4 cleared", 3'b000);

        // R8: set strobe and clear write meet on the same edge (secondary B).
        evt_sec_i = 2'b10;          // before edge 1
        @(negedge clk);             // after edge 1
        @(negedge clk);             // after edge 2: strobe active now
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd0;
        @(negedge clk);             // after edge 3
        reg_wr = 1'b0;
        check("R8 set wins", {30'd0, irq_main_o}, 32'd2);
        evt_sec_i = 2'b00;
        wait_negs(3);
        check_all("R8 R6 B only", 3'b100);

        // R1: reset mid-run clears everything.
        wr(2'd0, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check_all("R1 reset clears", 3'b000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule